// File: doc/BRIEF.md
# Dual-Event Shadow Register Update Controller

This block holds the preload and active copies of a motor-control timer's configuration and decides when the preload values take effect. Software writes preload values through a small indexed write port. Two independent update events move the values into the active copies that the counter core and the output stage use. The counter and the waveform logic are not part of this block.

The first event covers the timing group: the counter reload value, the prescaler value, and two compare-type values for each channel. A counter overflow, a counter underflow, a slave-mode restart pulse or a software strobe raises it. A disable input suppresses the event completely. A second input decides whether the event also sets the sticky update flag. The second event covers the output-control group: each channel's output enable, complementary-output enable and output-mode field. A software strobe raises it, and so does a rising edge on an asynchronous trigger line after that line has passed a two-flop synchroniser.

Top module: `shadow_update_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every preload value, every active value and the update flag are zero.
- R2: When `ovfPulse`, `udfPulse`, `slaveRestart` or `swEv1Gen` is high at a clock edge and `ev1Disable` is low, the active reload, prescaler, compare-A and compare-B values take their preload values at that edge.
- R3: While `ev1Disable` is high, none of the first-event sources changes any active timing value and none of them sets the update flag.
- R4: A first event that takes place with `irqDisable` low sets `updFlag` at the same edge. A first event that takes place with `irqDisable` high leaves `updFlag` unchanged.
- R5: A high `swEv2Gen` at a clock edge loads every channel's active output enable, complementary enable and mode from their preload values.
- R6: A 0-to-1 transition of `trigIn` that is set up before edge k loads the output-control group at edge k+2. The active values are unchanged after edge k+1. Holding `trigIn` high gives no further load.
- R7: A preload write changes no active value until the matching event fires. A first event leaves the output-control group unchanged, and a second event leaves the timing group unchanged.
- R8: When a preload write and the matching event happen at the same edge, the active copy receives the newly written value.
- R9: `updFlag` stays set until `flagClr` is high at an edge. A set in the same cycle wins over the clear. `updIrq` equals `updFlag` AND `irqEnable`.
- R10: `wrSel` picks the target of a write. Value 0 is the reload and value 1 is the prescaler. Values 2+i and 2+N+i are compare A and compare B of channel i. Value 2+2N+i is the control of channel i, with bit 0 as the output enable, bit 1 as the complementary enable and bits 2 and up as the mode. N is `NUM_CH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Preload write strobe |
| wrSel | input | SEL_W | Preload write target index |
| wrData | input | DATA_W | Preload write data |
| ovfPulse | input | 1 | Counter overflow pulse |
| udfPulse | input | 1 | Counter underflow pulse |
| slaveRestart | input | 1 | Slave-mode restart pulse |
| swEv1Gen | input | 1 | Software first-event strobe |
| swEv2Gen | input | 1 | Software second-event strobe |
| trigIn | input | 1 | Asynchronous trigger line |
| ev1Disable | input | 1 | Suppresses the first event |
| irqDisable | input | 1 | Stops the first event from setting the flag |
| irqEnable | input | 1 | Interrupt output enable |
| flagClr | input | 1 | Write-1 clear of the update flag |
| actReload | output | DATA_W | Active reload value |
| actPresc | output | DATA_W | Active prescaler value |
| actCmpA | output | NUM_CH*DATA_W | Active compare A, channel i at bits [i*DATA_W +: DATA_W] |
| actCmpB | output | NUM_CH*DATA_W | Active compare B, same packing |
| actOutEn | output | NUM_CH | Active output enables |
| actCompEn | output | NUM_CH | Active complementary enables |
| actOutMode | output | NUM_CH*MODE_W | Active output modes |
| updFlag | output | 1 | Sticky update flag |
| updIrq | output | 1 | Update interrupt |

## Verification
The assertions assume that the two software strobes are pulses lasting one cycle. They also assume that `wrSel` stays within the defined index range whenever `wrEn` is high, because indices outside that range write nothing. The random stimulus draws `wrSel` only from valid indices and raises each strobe for one cycle at a time. It holds `trigIn` over several cycles so that rising edges, high levels and falling edges all reach the synchroniser. The stable-value checks assume that no event strobe is active in the cycle being checked, and that no write is active either where the write path could reach the checked value.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef struct packed {
    logic ev1Load;  // timing group transfer
    logic ev2Load;  // output-control group transfer
  } upd_strobe_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ovfPulse,
  input  logic        udfPulse,
  input  logic        slaveRestart,
  input  logic        swEv1Gen,
  input  logic        swEv2Gen,
  input  logic        trigIn,
  input  logic        ev1Disable,
  input  logic        irqDisable,
  input  logic        flagClr,
  output upd_strobe_t strobes,
  output logic        updFlag
);
  logic trigMeta, trigSync, trigPrev, trigRise, ev1Req;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigMeta <= 1'b0;
      trigSync <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      trigMeta <= trigIn;
      trigSync <= trigMeta;
      trigPrev <= trigSync;
    end
  end

  assign trigRise        = trigSync & ~trigPrev;
  assign ev1Req          = ovfPulse | udfPulse | slaveRestart | swEv1Gen;
  assign strobes.ev1Load = ev1Req & ~ev1Disable;
  assign strobes.ev2Load = swEv2Gen | trigRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              updFlag <= 1'b0;
    else if (strobes.ev1Load && !irqDisable) updFlag <= 1'b1;
    else if (flagClr)                        updFlag <= 1'b0;
  end

  // R6: the edge detector yields an isolated single-cycle pulse
  assert_trig_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigRise |=> !trigRise);
  // R9: flag holds without a clear
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !flagClr) |=> updFlag);
  // R4: an enabled first event sets the flag
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ev1Req && !ev1Disable && !irqDisable) |=> updFlag);
  // R3: a disabled event cannot raise the flag
  assert_dis_noflag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ev1Disable && !updFlag) |=> !updFlag);
endmodule

// File: rtl/shadow_datapath.sv
module shadow_datapath
  import shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3,
  parameter int SEL_W  = 4
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  upd_strobe_t              strobes,
  output logic [DATA_W-1:0]        actReload,
  output logic [DATA_W-1:0]        actPresc,
  output logic [NUM_CH*DATA_W-1:0] actCmpA,
  output logic [NUM_CH*DATA_W-1:0] actCmpB,
  output logic [NUM_CH-1:0]        actOutEn,
  output logic [NUM_CH-1:0]        actCompEn,
  output logic [NUM_CH*MODE_W-1:0] actOutMode
);
  localparam int CTL_W    = MODE_W + 2;
  localparam int BASE_A   = 2;
  localparam int BASE_B   = 2 + NUM_CH;
  localparam int BASE_CTL = 2 + 2 * NUM_CH;

  logic [DATA_W-1:0] preReload, prePresc, nxtReload, nxtPresc;

  assign nxtReload = (wrEn && wrSel == SEL_W'(0)) ? wrData : preReload;
  assign nxtPresc  = (wrEn && wrSel == SEL_W'(1)) ? wrData : prePresc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preReload <= '0;
      prePresc  <= '0;
      actReload <= '0;
      actPresc  <= '0;
    end else begin
      preReload <= nxtReload;
      prePresc  <= nxtPresc;
      if (strobes.ev1Load) begin
        actReload <= nxtReload;
        actPresc  <= nxtPresc;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] preA, preB, nxtA, nxtB;
    logic [CTL_W-1:0]  preCtl, nxtCtl, actCtl;

    assign nxtA   = (wrEn && wrSel == SEL_W'(BASE_A + ch)) ? wrData : preA;
    assign nxtB   = (wrEn && wrSel == SEL_W'(BASE_B + ch)) ? wrData : preB;
    assign nxtCtl = (wrEn && wrSel == SEL_W'(BASE_CTL + ch)) ? wrData[CTL_W-1:0] : preCtl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preA   <= '0;
        preB   <= '0;
        preCtl <= '0;
        actCmpA[ch*DATA_W +: DATA_W] <= '0;
        actCmpB[ch*DATA_W +: DATA_W] <= '0;
        actCtl <= '0;
      end else begin
        preA   <= nxtA;
        preB   <= nxtB;
        preCtl <= nxtCtl;
        if (strobes.ev1Load) begin
          actCmpA[ch*DATA_W +: DATA_W] <= nxtA;
          actCmpB[ch*DATA_W +: DATA_W] <= nxtB;
        end
        if (strobes.ev2Load) actCtl <= nxtCtl;
      end
    end

    assign actOutEn[ch]                   = actCtl[0];
    assign actCompEn[ch]                  = actCtl[1];
    assign actOutMode[ch*MODE_W +: MODE_W] = actCtl[CTL_W-1:2];
  end

  // R7: timing group frozen while no first event
  assert_timing_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ev1Load |=> ($stable(actPresc) && $stable(actCmpA) && $stable(actCmpB)));
  // R7: output-control group frozen while no second event
  assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ev2Load |=> ($stable(actOutEn) && $stable(actCompEn) && $stable(actOutMode)));
endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
  import shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3,
  localparam int SEL_W = $clog2(2 + 3 * NUM_CH)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     ovfPulse,
  input  logic                     udfPulse,
  input  logic                     slaveRestart,
  input  logic                     swEv1Gen,
  input  logic                     swEv2Gen,
  input  logic                     trigIn,
  input  logic                     ev1Disable,
  input  logic                     irqDisable,
  input  logic                     irqEnable,
  input  logic                     flagClr,
  output logic [DATA_W-1:0]        actReload,
  output logic [DATA_W-1:0]        actPresc,
  output logic [NUM_CH*DATA_W-1:0] actCmpA,
  output logic [NUM_CH*DATA_W-1:0] actCmpB,
  output logic [NUM_CH-1:0]        actOutEn,
  output logic [NUM_CH-1:0]        actCompEn,
  output logic [NUM_CH*MODE_W-1:0] actOutMode,
  output logic                     updFlag,
  output logic                     updIrq
);
  upd_strobe_t strobes;

  shadow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ovfPulse(ovfPulse), .udfPulse(udfPulse),
    .slaveRestart(slaveRestart), .swEv1Gen(swEv1Gen), .swEv2Gen(swEv2Gen),
    .trigIn(trigIn), .ev1Disable(ev1Disable), .irqDisable(irqDisable),
    .flagClr(flagClr), .strobes(strobes), .updFlag(updFlag)
  );

  shadow_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .MODE_W(MODE_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobes(strobes), .actReload(actReload), .actPresc(actPresc),
    .actCmpA(actCmpA), .actCmpB(actCmpB), .actOutEn(actOutEn),
    .actCompEn(actCompEn), .actOutMode(actOutMode)
  );

  assign updIrq = updFlag & irqEnable;

  // R3: a disabled first event leaves the reload untouched (write to it excluded)
  assert_dis_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ev1Disable && !(wrEn && wrSel == SEL_W'(0))) |=> $stable(actReload));
endmodule

// File: tb/shadow_update_ctrl_bench.sv
module shadow_update_ctrl_bench;
  localparam int N     = 4;
  localparam int DW    = 16;
  localparam int MW    = 3;
  localparam int NSEL  = 2 + 3 * N;
  localparam int SW    = $clog2(NSEL);
  localparam int CBASE = 2 + 2 * N;

  logic clk = 0, rstN = 0;
  logic wrEn = 0, ovf = 0, udf = 0, sr = 0, sw1 = 0, sw2 = 0, trig = 0;
  logic dis1 = 0, irqDis = 0, irqEn = 0, clr = 0;
  logic [SW-1:0] wrSel = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] actReload, actPresc;
  logic [N*DW-1:0] actCmpA, actCmpB;
  logic [N-1:0] actOutEn, actCompEn;
  logic [N*MW-1:0] actOutMode;
  logic updFlag, updIrq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] mPre [NSEL];
  logic [DW-1:0] mAct [NSEL];
  logic t1 = 0, t2 = 0, t3 = 0, mFlag = 0;

  always #4 clk = ~clk;

  shadow_update_ctrl #(.NUM_CH(N), .DATA_W(DW), .MODE_W(MW)) u_shadow_update_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ovfPulse(ovf), .udfPulse(udf), .slaveRestart(sr), .swEv1Gen(sw1),
    .swEv2Gen(sw2), .trigIn(trig), .ev1Disable(dis1), .irqDisable(irqDis),
    .irqEnable(irqEn), .flagClr(clr), .actReload(actReload), .actPresc(actPresc),
    .actCmpA(actCmpA), .actCmpB(actCmpB), .actOutEn(actOutEn),
    .actCompEn(actCompEn), .actOutMode(actOutMode), .updFlag(updFlag), .updIrq(updIrq)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N*DW-1:0] expCmp(int base);
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = mAct[base + i];
    return v;
  endfunction

  function automatic logic [N-1:0] expBit(int b);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = mAct[CBASE + i][b];
    return v;
  endfunction

  function automatic logic [N*MW-1:0] expMode();
    logic [N*MW-1:0] v;
    for (int i = 0; i < N; i++) v[i*MW +: MW] = mAct[CBASE + i][MW+1:2];
    return v;
  endfunction

  task automatic compareAll(string tag);
    chk(tag, "reload", 64'(actReload), 64'(mAct[0]));
    chk(tag, "presc", 64'(actPresc), 64'(mAct[1]));
    chk(tag, "cmpA", 64'(actCmpA), 64'(expCmp(2)));
    chk(tag, "cmpB", 64'(actCmpB), 64'(expCmp(2 + N)));
    chk(tag, "outEn", 64'(actOutEn), 64'(expBit(0)));
    chk(tag, "compEn", 64'(actCompEn), 64'(expBit(1)));
    chk(tag, "mode", 64'(actOutMode), 64'(expMode()));
    chk(tag, "flag", 64'(updFlag), 64'(mFlag));
    chk(tag, "irq", 64'(updIrq), 64'(mFlag & irqEn));
  endtask

  // model advance for one edge, then compare after it (called at negedge)
  task automatic step(string tag);
    logic ev1, ev2;
    ev1 = (ovf | udf | sr | sw1) & ~dis1;
    ev2 = sw2 | (t2 & ~t3);
    if (wrEn && int'(wrSel) < NSEL) mPre[wrSel] = wrData;
    for (int i = 0; i < NSEL; i++) begin
      if (i < CBASE && ev1) mAct[i] = mPre[i];
      if (i >= CBASE && ev2) mAct[i] = mPre[i];
    end
    if (ev1 && !irqDis) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    t3 = t2; t2 = t1; t1 = trig;
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle();
    wrEn = 0; ovf = 0; udf = 0; sr = 0; sw1 = 0; sw2 = 0;
    dis1 = 0; irqDis = 0; clr = 0;
  endtask

  task automatic wr(int sel, int data);
    wrEn = 1; wrSel = SW'(sel); wrData = DW'(data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSEL; i++) begin mPre[i] = '0; mAct[i] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    compareAll("R1");
    // R10/R7: writes without an event leave active values at zero
    wr(0, 'h1234); step("R7");
    wr(1, 'h0042); step("R7");
    wr(CBASE + 2, 'h1f); step("R7");
    idle(); step("R7");
    // R2: each first-event source
    ovf = 1; step("R2"); idle();
    wr(2 + N, 'hbeef); step("R7"); idle();
    udf = 1; step("R2"); idle();
    wr(3, 'h0101); step("R7"); idle();
    sr = 1; step("R2"); idle();
    wr(1, 'h0055); step("R7"); idle();
    sw1 = 1; step("R2"); idle();
    // R8: write and event in the same cycle
    wr(2, 'hcafe); ovf = 1; step("R8"); idle();
    wr(CBASE, 'h0e); sw2 = 1; step("R8"); idle();
    // R3: disabled first event
    clr = 1; step("R9"); idle();
    wr(0, 'h7777); step("R7"); idle();
    dis1 = 1; ovf = 1; udf = 1; sr = 1; sw1 = 1; step("R3"); idle();
    // R4: interrupt generation disabled
    irqDis = 1; ovf = 1; step("R4"); idle();
    // R9: set and clear
    ovf = 1; step("R4"); idle();
    irqEn = 1; step("R9");
    step("R9");
    ovf = 1; clr = 1; step("R9"); idle();
    clr = 1; step("R9"); idle();
    irqEn = 0;
    // R5: software second event
    wr(CBASE + 3, 'h17); step("R7"); idle();
    sw2 = 1; step("R5"); idle();
    // R6: trigger edge timing and held level
    wr(CBASE + 1, 'h0b); step("R7"); idle();
    trig = 1; step("R6"); step("R6"); step("R6");
    wr(CBASE + 1, 'h12); step("R6"); idle();
    step("R6"); step("R6");
    trig = 0; step("R6"); step("R6"); step("R6");
    trig = 1; step("R6"); step("R6"); step("R6");
    // random mix
    for (int c = 0; c < 3000; c++) begin
      wrEn   = ($urandom % 3) == 0;
      wrSel  = SW'($urandom % NSEL);
      wrData = DW'($urandom);
      ovf    = ($urandom % 8) == 0;
      udf    = ($urandom % 8) == 0;
      sr     = ($urandom % 16) == 0;
      sw1    = ($urandom % 16) == 0;
      sw2    = ($urandom % 16) == 0;
      dis1   = ($urandom % 4) == 0;
      irqDis = ($urandom % 4) == 0;
      irqEn  = ($urandom % 2) == 0;
      clr    = ($urandom % 6) == 0;
      if (($urandom % 6) == 0) trig = ~trig;
      step("R7");
    end
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule